// File: doc/BRIEF.md
# Bitwise Logic and Register Compare Flag Unit

This execution unit retires two instruction classes of a 16-bit register machine. The bitwise class combines two source registers with AND, OR or XOR. The result can be complemented before it is written back. An optional zero test then examines the final value, can invert its outcome, and places it in one of two condition flags. The compare class checks two registers as unsigned numbers for equal, less-than or greater-than. It writes the outcome, optionally inverted, to a selected flag and never writes a register.

The unit decodes a two-word instruction presented with `issue`. It exports the two source register indices combinationally, so the register file can return their data in the same cycle. One clock later it presents the registered destination write, the flag state and the program counter advance. An unusable sub-opcode produces a one-cycle halt instead. Predicate gating is done upstream, so every issued instruction of either class executes. A small state machine sequences the result. `ST_IDLE` is the state with nothing retiring. `ST_RETIRE` presents a legal result with a PC advance of 2. `ST_HALT` presents an illegal sub-opcode. Transitions happen every clock: `issue` with a legal instruction goes to `ST_RETIRE`, `issue` with an illegal sub-opcode goes to `ST_HALT`, and no issue or a foreign class goes to `ST_IDLE`. These transitions are taken from any state, so back-to-back issue is allowed.

Top module: `lcf_unit`

## Requirements
- R1: During and directly after reset, `rd_we`, `halt`, `pc_delta` and both flags are 0.
- R2: The class field is word0[11:8]. Class 2 is bitwise, and word0[3:0] selects 0 AND, 1 OR, 2 XOR of the data at index word1[15:11] (first operand) and word1[10:6] (second). One cycle after issue, `rd_we` is 1, `rd_idx` is word1[5:1] and `pc_delta` is 2.
- R3: When word0[4] is set on a bitwise instruction, the bitwise complement of the result is written.
- R4: When word0[7] is set on a bitwise instruction, flag word0[6] (0 selects `flags[0]`, 1 selects `flags[1]`) becomes (final result == 0) XOR word0[5], where the final result is taken after the R3 complement. The other flag holds. With word0[7] clear, neither flag changes.
- R5: A bitwise destination of index 31 gives no register write, but the R4 flag update and the PC advance of 2 still happen.
- R6: Class 3 is compare. Word0[5:4] selects 0 equal, 1 less-than, 2 greater-than, with the first operand on the left and both treated as unsigned. Flag word0[7] becomes the outcome XOR word0[6], the other flag holds, no register is written and `pc_delta` is 2.
- R7: A bitwise sub-op of 3 to 15, or compare mode 3, raises `halt` for exactly one cycle with no register write, no flag change and `pc_delta` 0.
- R8: Any cycle without `issue`, or an issue whose class is neither 2 nor 3, gives no write, no halt, `pc_delta` 0 and unchanged flags in the next cycle.
- R9: `src_a_idx` and `src_b_idx` follow word1[15:11] and word1[10:6] combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Instruction words and operand data are valid |
| word0 | input | 16 | First instruction word (class, sub-op, control bits) |
| word1 | input | 16 | Second instruction word (register indices) |
| src_a_idx | output | 5 | Index of the first operand register |
| src_b_idx | output | 5 | Index of the second operand register |
| src_a_data | input | 16 | Data of the first operand register |
| src_b_data | input | 16 | Data of the second operand register |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 16 | Destination write data |
| flags | output | 2 | Condition flags, index 0 and 1 |
| pc_delta | output | 2 | Program counter advance (2 on retire, else 0) |
| halt | output | 1 | One-cycle pulse for an illegal sub-opcode |

## Verification
The bench first runs directed cases: the three bitwise operations on fixed bit patterns, an inverted all-zero result that fails the zero test, and a zero result whose test is itself inverted. These show whether the complement is applied before or after the zero test. A write aimed at index 31 shows that the flag update is separated from the write suppression. Equal, smaller and larger operand pairs, including values with the top bit set, tell an unsigned compare from a signed one. A random mix of both classes, illegal sub-ops and foreign classes follows, with operands often forced equal so that zero and equal outcomes occur often. The back-to-back issues in this mix show whether the flag that was not selected keeps its value.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

    localparam int FIELD_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RETIRE = 2'd1,
        ST_HALT   = 2'd2
    } lcf_state_e;

    typedef enum logic [1:0] {
        BOP_AND = 2'd0,
        BOP_OR  = 2'd1,
        BOP_XOR = 2'd2
    } lcf_bop_e;

    typedef enum logic [1:0] {
        CMP_EQ  = 2'd0,
        CMP_LT  = 2'd1,
        CMP_GT  = 2'd2,
        CMP_BAD = 2'd3
    } lcf_cmp_e;

    typedef struct packed {
        logic               is_bit;
        logic               is_cmp;
        logic               legal;
        lcf_bop_e           bop;
        logic               res_inv;
        logic               zt_en;
        logic               zt_inv;
        logic               bit_fsel;
        lcf_cmp_e           cmode;
        logic               cmp_inv;
        logic               cmp_fsel;
        logic [FIELD_W-1:0] dst;
    } lcf_dec_t;

endpackage

// File: rtl/lcf_decode.sv
module lcf_decode
    import lcf_pkg::*;
(
    input  logic [15:0] word0,
    input  logic [15:0] word1,
    output lcf_dec_t    dec
);
    localparam logic [3:0] CLASS_BIT = 4'd2;
    localparam logic [3:0] CLASS_CMP = 4'd3;

    always_comb begin
        dec          = '0;
        dec.is_bit   = (word0[11:8] == CLASS_BIT);
        dec.is_cmp   = (word0[11:8] == CLASS_CMP);
        dec.bop      = lcf_bop_e'(word0[1:0]);
        dec.res_inv  = word0[4];
        dec.zt_en    = word0[7];
        dec.bit_fsel = word0[6];
        dec.zt_inv   = word0[5];
        dec.cmode    = lcf_cmp_e'(word0[5:4]);
        dec.cmp_fsel = word0[7];
        dec.cmp_inv  = word0[6];
        dec.dst      = word1[5:1];
        unique case (1'b1)
            dec.is_bit: dec.legal = (word0[3:0] <= 4'd2);
            dec.is_cmp: dec.legal = (word0[5:4] != 2'd3);
            default:    dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/lcf_bitwise.sv
module lcf_bitwise
    import lcf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  lcf_bop_e          bop,
    input  logic              res_inv,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              is_zero
);
    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (bop)
            BOP_AND: raw = a & b;
            BOP_OR:  raw = a | b;
            BOP_XOR: raw = a ^ b;
            default: raw = '0;
        endcase
        result  = res_inv ? ~raw : raw;
        is_zero = (result == '0);
    end
endmodule

// File: rtl/lcf_compare.sv
module lcf_compare
    import lcf_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  lcf_cmp_e          cmode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              outcome
);
    logic eq, lt, gt;

    always_comb begin
        eq = (a == b);
        lt = (a < b);
        gt = (a > b);
        unique case (cmode)
            CMP_EQ:  outcome = eq;
            CMP_LT:  outcome = lt;
            CMP_GT:  outcome = gt;
            default: outcome = 1'b0;
        endcase
        if (!$isunknown({a, b})) begin
            assert_order_exclusive_R6: assert ($countones({eq, lt, gt}) == 1)
                else $error("compare relations not exclusive");
        end
    end
endmodule

// File: rtl/lcf_unit.sv
module lcf_unit
    import lcf_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 32,
    parameter int PC_STEP  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        issue,
    input  logic [15:0]                 word0,
    input  logic [15:0]                 word1,
    output logic [$clog2(NUM_REGS)-1:0] src_a_idx,
    output logic [$clog2(NUM_REGS)-1:0] src_b_idx,
    input  logic [DATA_W-1:0]           src_a_data,
    input  logic [DATA_W-1:0]           src_b_data,
    output logic                        rd_we,
    output logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic [DATA_W-1:0]           rd_data,
    output logic [1:0]                  flags,
    output logic [$clog2(PC_STEP+1)-1:0] pc_delta,
    output logic                        halt
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int PC_W  = $clog2(PC_STEP + 1);
    localparam logic [IDX_W-1:0] PROT_IDX = IDX_W'(NUM_REGS - 1);

    lcf_dec_t          dec;
    lcf_state_e        state, state_nx;
    logic [DATA_W-1:0] bit_res;
    logic              bit_zero;
    logic              cmp_out;
    logic              go;
    logic              flag_we;
    logic              flag_sel;
    logic              flag_val;
    logic [IDX_W-1:0]  dst_idx;

    assign src_a_idx = IDX_W'(word1[15:11]);
    assign src_b_idx = IDX_W'(word1[10:6]);
    assign dst_idx   = IDX_W'(dec.dst);

    lcf_decode u_dec (.word0(word0), .word1(word1), .dec(dec));

    lcf_bitwise #(.DATA_W(DATA_W)) u_bit (
        .bop(dec.bop), .res_inv(dec.res_inv), .a(src_a_data), .b(src_b_data),
        .result(bit_res), .is_zero(bit_zero)
    );

    lcf_compare #(.DATA_W(DATA_W)) u_cmp (
        .cmode(dec.cmode), .a(src_a_data), .b(src_b_data), .outcome(cmp_out)
    );

    always_comb begin
        go       = issue && dec.legal;
        flag_we  = go && ((dec.is_bit && dec.zt_en) || dec.is_cmp);
        flag_sel = dec.is_cmp ? dec.cmp_fsel : dec.bit_fsel;
        flag_val = dec.is_cmp ? (cmp_out ^ dec.cmp_inv) : (bit_zero ^ dec.zt_inv);
        if (!issue || !(dec.is_bit || dec.is_cmp)) state_nx = ST_IDLE;
        else if (!dec.legal)                       state_nx = ST_HALT;
        else                                       state_nx = ST_RETIRE;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_we   <= 1'b0;
            rd_idx  <= '0;
            rd_data <= '0;
            flags   <= 2'b00;
        end else begin
            rd_we <= go && dec.is_bit && (dst_idx != PROT_IDX);
            if (go && dec.is_bit) begin
                rd_idx  <= dst_idx;
                rd_data <= bit_res;
            end
            if (flag_we) flags[flag_sel] <= flag_val;
        end
    end

    always_comb begin
        halt     = 1'b0;
        pc_delta = '0;
        unique case (state)
            ST_IDLE:   ;
            ST_RETIRE: pc_delta = PC_W'(PC_STEP);
            ST_HALT:   halt = 1'b1;
            default:   ;
        endcase
    end

    assert_guard_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> (rd_idx != PROT_IDX))
        else $error("protected register written");

    assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue && dec.is_cmp) |-> !rd_we)
        else $error("compare wrote a register");

    assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!rd_we && pc_delta == '0 && $stable(flags)))
        else $error("halt with side effect");

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(issue) |-> (!rd_we && !halt && pc_delta == '0 && $stable(flags)))
        else $error("activity without issue");

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(issue && dec.legal) |-> (pc_delta == PC_W'(PC_STEP)))
        else $error("missing PC advance");

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(go && dec.is_bit && dec.zt_en) |->
            (flags[$past(dec.bit_fsel)] == ($past(bit_res == '0) ^ $past(dec.zt_inv))))
        else $error("zero-test flag mismatch");
endmodule

// File: tb/tb_lcf_unit.sv
module tb_lcf_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [15:0] word0, word1, a_data, b_data;
    logic [4:0]  src_a_idx, src_b_idx, rd_idx;
    logic        rd_we, halt;
    logic [15:0] rd_data;
    logic [1:0]  flags, pc_delta;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] exp_flags = 2'b00;

    always #2 clk = ~clk;

    lcf_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .word0(word0), .word1(word1),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_data(a_data), .src_b_data(b_data),
        .rd_we(rd_we), .rd_idx(rd_idx), .rd_data(rd_data),
        .flags(flags), .pc_delta(pc_delta), .halt(halt)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] bit_ref(input logic [15:0] w0, input logic [15:0] a,
                                            input logic [15:0] b);
        logic [15:0] r;
        case (w0[3:0])
            4'd0:    r = a & b;
            4'd1:    r = a | b;
            default: r = a ^ b;
        endcase
        return w0[4] ? ~r : r;
    endfunction

    // Drive one instruction, then check every output one clock later.
    task automatic run(input logic [15:0] w0, input logic [15:0] w1,
                       input logic [15:0] a, input logic [15:0] b);
        logic        e_we, e_halt;
        logic [1:0]  e_pc;
        logic [15:0] e_data;
        logic        legal;
        logic [15:0] r;
        string       tag;
        @(negedge clk);
        issue = 1'b1; word0 = w0; word1 = w1; a_data = a; b_data = b;
        #1;
        chk(src_a_idx == w1[15:11] && src_b_idx == w1[10:6], "R9 src idx",
            {src_a_idx, src_b_idx}, {w1[15:11], w1[10:6]});
        e_we = 0; e_halt = 0; e_pc = 0; e_data = 0; tag = "R8 foreign";
        if (w0[11:8] == 4'd2) begin
            legal = (w0[3:0] <= 4'd2);
            if (!legal) begin e_halt = 1; tag = "R7 bit halt"; end
            else begin
                r = bit_ref(w0, a, b);
                e_pc = 2; e_data = r;
                e_we = (w1[5:1] != 5'd31);
                tag = (w1[5:1] == 5'd31) ? "R5 dst31" : (w0[4] ? "R3 inv" : "R2 bitwise");
                if (w0[7]) begin
                    exp_flags[w0[6]] = (r == 16'd0) ^ w0[5];
                    if (e_we) tag = "R4 zero test";
                end
            end
        end else if (w0[11:8] == 4'd3) begin
            if (w0[5:4] == 2'd3) begin e_halt = 1; tag = "R7 cmp halt"; end
            else begin
                e_pc = 2; tag = "R6 compare";
                case (w0[5:4])
                    2'd0:    exp_flags[w0[7]] = (a == b) ^ w0[6];
                    2'd1:    exp_flags[w0[7]] = (a <  b) ^ w0[6];
                    default: exp_flags[w0[7]] = (a >  b) ^ w0[6];
                endcase
            end
        end
        @(posedge clk); #1;
        chk(rd_we == e_we, {tag, " we"}, rd_we, e_we);
        if (e_we) begin
            chk(rd_idx == w1[5:1], {tag, " idx"}, rd_idx, w1[5:1]);
            chk(rd_data == e_data, {tag, " data"}, rd_data, e_data);
        end
        chk(halt == e_halt, {tag, " halt"}, halt, e_halt);
        chk(pc_delta == e_pc, {tag, " pc"}, pc_delta, e_pc);
        chk(flags == exp_flags, {tag, " flags"}, flags, exp_flags);
        issue = 1'b0;
    endtask

    // w1 with sources 1,2 and destination d
    function automatic logic [15:0] ops(input logic [4:0] d);
        return {5'd1, 5'd2, d, 1'b0};
    endfunction

    initial begin
        #300000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; issue = 0; word0 = 0; word1 = 0; a_data = 0; b_data = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(!rd_we && !halt && pc_delta == 0 && flags == 0, "R1 in reset",
            {rd_we, halt, pc_delta, flags}, 0);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        chk(!rd_we && !halt && pc_delta == 0 && flags == 0, "R1 after reset",
            {rd_we, halt, pc_delta, flags}, 0);

        // directed: the three operations
        run(16'h0200, ops(5'd3), 16'b11010, 16'b10110);
        run(16'h0201, ops(5'd4), 16'b10010, 16'b11000);
        run(16'h0202, ops(5'd5), 16'b01101, 16'b01011);
        // inversion then zero test: ~(0&x) = FFFF, not zero -> flag1 = 0^1 = 1
        run(16'h02F0, ops(5'd6), 16'h0000, 16'h1234);
        // zero result, zero test with invert into flag0 -> 1^1 = 0; flag1 holds
        run(16'h02A2, ops(5'd7), 16'h5A5A, 16'h5A5A);
        // destination 31: no write, flag0 = (0==0) -> 1
        run(16'h0280, ops(5'd31), 16'h00F0, 16'h0F00);
        // unsigned compares with top bit set
        run(16'h0310, ops(5'd0), 16'h0001, 16'h8000);
        run(16'h03A0, ops(5'd0), 16'h8000, 16'h0001);
        run(16'h0300, ops(5'd0), 16'h7777, 16'h7777);
        run(16'h0340, ops(5'd0), 16'h7777, 16'h7777);
        // illegal sub-ops and foreign class
        run(16'h0203, ops(5'd8), 16'h1, 16'h2);
        run(16'h02FF, ops(5'd8), 16'h1, 16'h2);
        run(16'h03B0, ops(5'd8), 16'h1, 16'h2);
        run(16'h01F0, ops(5'd9), 16'h1, 16'h2);
        // idle cycle
        @(negedge clk); issue = 0;
        @(posedge clk); #1;
        chk(!rd_we && !halt && pc_delta == 0 && flags == exp_flags, "R8 idle",
            {rd_we, halt, pc_delta, flags}, exp_flags);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            logic [15:0] w0, w1, a, b;
            int unsigned pick;
            pick = $urandom % 8;
            w0 = 16'($urandom);
            w1 = 16'($urandom);
            a  = 16'($urandom);
            b  = ($urandom % 3 == 0) ? a : 16'($urandom);
            if ($urandom % 4 == 0) b = ~a;
            if (pick < 4) begin
                w0[11:8] = 4'd2;
                if ($urandom % 6 != 0) w0[3:0] = 4'($urandom % 3);
            end else if (pick < 7) w0[11:8] = 4'd3;
            else if (w0[11:8] inside {4'd2, 4'd3}) w0[11:8] = 4'd5;
            if ($urandom % 10 == 0) w1[5:1] = 5'd31;
            run(w0, w1, a, b);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule